// File: doc/BRIEF.md
# Configurable External Interrupt Edge Detector

The block watches one asynchronous external pin and raises an interrupt request when the pin makes a qualifying transition. A 4-bit control word sets its behaviour. The word is written from, and read back into, a 4-bit accumulator. Two of its bits choose what counts as a qualifying transition: one chooses single-edge or both-edge detection, and the other chooses polarity. The polarity bit also sets the level that a software level test reports. A third bit passes straight out as a gating enable for a neighbouring timer. The fourth bit holds its value and has no other use.

The pin passes through a synchronizer and is then compared with its own value one cycle earlier. The request flag stays set until software pulses the clear strobe. In single-edge mode, flipping the polarity bit can make the block see an edge that the pin never made, and this raises the request flag. Software is expected to clear the flag after such a write.

Top module: `xint_edge_ctrl`

## Requirements
- R1: After reset, rd_data_o is 0000, req_o is 0 and timer_en_o is 0.
- R2: A write (wr_en_i high at a clock edge) loads wr_data_i into the control word. From the next cycle, rd_data_o returns all four bits unchanged, including the spare bit 3.
- R3: While wr_en_i is low, the control word keeps its value whatever wr_data_i carries. Only a write or reset changes it.
- R4: timer_en_o equals control bit 0.
- R5: With bit 1 = 0 and bit 2 = 0, a falling pin edge sets req_o and a rising edge does not.
- R6: With bit 1 = 0 and bit 2 = 1, a rising pin edge sets req_o and a falling edge does not.
- R7: With bit 1 = 1, both pin edges set req_o, whatever the value of bit 2.
- R8: A pin change that is first sampled at clock edge 1 sets req_o at clock edge 3, and not earlier.
- R9: level_hit_o is 1 when the synchronized pin equals bit 2, so bit 2 = 0 reports a low level and bit 2 = 1 a high level. It follows a pin change at the second clock edge.
- R10: A write that changes bit 2, with the new bit 1 = 0, sets req_o at that same edge when the synchronized pin already equals the new bit 2. A write under any other condition does not set req_o.
- R11: Once set, req_o stays high until a clock edge with clr_i high clears it.
- R12: If a set condition and clr_i coincide at an edge, req_o is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 4 | Control word write data from accumulator |
| rd_data_o | output | 4 | Control word read data |
| pin_i | input | 1 | Asynchronous external pin |
| clr_i | input | 1 | Request flag clear strobe |
| level_hit_o | output | 1 | Pin is at the level chosen by polarity bit |
| req_o | output | 1 | Interrupt request flag |
| timer_en_o | output | 1 | Timer gating enable |

## Verification
A corrupted control bit shows up at rd_data_o in the cycle after the write. It also changes which pin transitions reach req_o on the third clock edge after the pin moves. A wrong edge-history flop either misses a request or raises a false one, and the sweep catches this because it drives every transition direction under all sixteen control words. A fault in the polarity-flip artifact appears at req_o in the cycle after the write, and an exhaustive sweep over old word, new word and pin level exposes it.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int CTRL_W    = 4;
  localparam int TMR_BIT   = 0;
  localparam int MODE_BIT  = 1;
  localparam int POL_BIT   = 2;
  localparam int SPARE_BIT = 3;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= 1'b0;
      else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xint_cfg_reg.sv
module xint_cfg_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q;

  // retained across back-up; only reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= wr_data_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/xint_edge_det.sv
module xint_edge_det
  import xint_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_s_i,
  input  logic [CTRL_W-1:0] cfg_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              clr_i,
  output logic              req_set_o,
  output logic              req_o,
  output logic              level_hit_o
);
  logic pin_q;
  logic rise, fall, edge_hit, pol_art;
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_s_i;
  end

  assign rise = pin_s_i & ~pin_q;
  assign fall = ~pin_s_i & pin_q;

  always_comb begin
    if (cfg_i[MODE_BIT]) edge_hit = rise | fall;
    else if (cfg_i[POL_BIT]) edge_hit = rise;
    else edge_hit = fall;
  end

  // polarity flip in single-edge mode looks like an edge if pin sits at new post-edge level
  assign pol_art = wr_en_i
                 && (wr_data_i[POL_BIT] != cfg_i[POL_BIT])
                 && !wr_data_i[MODE_BIT]
                 && (pin_s_i == wr_data_i[POL_BIT]);

  assign req_set_o = edge_hit | pol_art;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        req_q <= 1'b0;
    else if (req_set_o) req_q <= 1'b1;
    else if (clr_i)     req_q <= 1'b0;
  end

  assign req_o       = req_q;
  assign level_hit_o = (pin_s_i == cfg_i[POL_BIT]);
endmodule

// File: rtl/xint_edge_ctrl.sv
module xint_edge_ctrl
  import xint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  input  logic              pin_i,
  input  logic              clr_i,
  output logic              level_hit_o,
  output logic              req_o,
  output logic              timer_en_o
);
  logic              pin_s;
  logic              req_set;
  logic [CTRL_W-1:0] cfg;

  xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  xint_cfg_reg #(.W(CTRL_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  xint_edge_det u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_s_i     (pin_s),
    .cfg_i       (cfg),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .clr_i       (clr_i),
    .req_set_o   (req_set),
    .req_o       (req_o),
    .level_hit_o (level_hit_o)
  );

  assign rd_data_o  = cfg;
  assign timer_en_o = cfg[TMR_BIT];
endmodule

// File: rtl/xint_edge_ctrl_chk.sv
module xint_edge_ctrl_chk
  import xint_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [CTRL_W-1:0] wr_data_i,
  input logic [CTRL_W-1:0] rd_data_o,
  input logic              clr_i,
  input logic              req_o,
  input logic              level_hit_o,
  input logic              timer_en_o,
  input logic              req_set_i,
  input logic              pin_sync_i
);
  AST_WR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o)); // R3
  AST_TIMER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_en_o == rd_data_o[TMR_BIT]); // R4
  AST_LEVEL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_hit_o == (pin_sync_i == rd_data_o[POL_BIT])); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !clr_i |=> req_o); // R11
  AST_REQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !req_set_i |=> !req_o); // R11
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_set_i |=> req_o); // R12
  AST_NO_SPURIOUS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(req_set_i)); // R10
endmodule

bind xint_edge_ctrl xint_edge_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .clr_i       (clr_i),
  .req_o       (req_o),
  .level_hit_o (level_hit_o),
  .timer_en_o  (timer_en_o),
  .req_set_i   (req_set),
  .pin_sync_i  (pin_s)
);

// File: tb/xint_edge_ctrl_test.sv
`timescale 1ns/1ps
module xint_edge_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_data_i = '0;
  logic [3:0] rd_data_o;
  logic       pin_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       level_hit_o, req_o, timer_en_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xint_edge_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .pin_i       (pin_i),
    .clr_i       (clr_i),
    .level_hit_o (level_hit_o),
    .req_o       (req_o),
    .timer_en_o  (timer_en_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] v);
    wr_en_i = 1'b1; wr_data_i = v;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic clear_req();
    clr_i = 1'b1;
    tick();
    clr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    check("R1 rd_data", int'(rd_data_o), 0);
    check("R1 req", int'(req_o), 0);
    check("R1 timer_en", int'(timer_en_o), 0);
    rst_ni = 1'b1;
    tick();

    // R3: data toggling without strobe
    write_cfg(4'b1010);
    for (int d = 0; d < 16; d++) begin
      wr_data_i = 4'(d);
      tick();
      check("R3 hold", int'(rd_data_o), 10);
    end

    // R2, R4, R9, R10: sweep old word, new word, pin level
    for (int p = 0; p < 2; p++) begin
      pin_i = p[0];
      tick(4);
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [3:0] av, bv;
          int art;
          av = 4'(a); bv = 4'(b);
          write_cfg(av);
          clear_req();
          check("R11 cleared", int'(req_o), 0);
          write_cfg(bv);
          art = (av[2] != bv[2]) && !bv[1] && (p[0] == bv[2]);
          check("R2 readback", int'(rd_data_o), b);
          check("R4 timer_en", int'(timer_en_o), int'(bv[0]));
          check("R10 polarity flip", int'(req_o), art);
          check("R9 level", int'(level_hit_o), int'(p[0] == bv[2]));
        end
      end
    end

    // R5, R6, R7, R8, R9, R11: edges under every word
    for (int c = 0; c < 16; c++) begin
      for (int dir = 0; dir < 2; dir++) begin
        logic [3:0] cv;
        int exp_req;
        string tag;
        cv = 4'(c);
        pin_i = ~dir[0];
        tick(4);
        write_cfg(cv);
        clear_req();
        check("R11 cleared", int'(req_o), 0);
        if (cv[1]) begin exp_req = 1; tag = "R7"; end
        else if (cv[2]) begin exp_req = dir; tag = "R6"; end
        else begin exp_req = 1 - dir; tag = "R5"; end
        pin_i = dir[0];
        tick();
        check("R9 level before", int'(level_hit_o), int'(~dir[0] == cv[2]));
        tick();
        check("R8 not yet", int'(req_o), 0);
        check("R9 level after", int'(level_hit_o), int'(dir[0] == cv[2]));
        tick();
        check(tag, int'(req_o), exp_req);
        tick(3);
        check("R11 holds", int'(req_o), exp_req);
        clear_req();
        check("R11 clear", int'(req_o), 0);
      end
    end

    // R12: clear held across the set edge
    write_cfg(4'b0010);
    pin_i = 1'b0;
    tick(4);
    clear_req();
    pin_i = 1'b1;
    clr_i = 1'b1;
    tick(3);
    check("R12 set wins", int'(req_o), 1);
    clr_i = 1'b0;
    tick();
    check("R12 stays", int'(req_o), 1);
    clear_req();
    check("R11 clear", int'(req_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule